// File: doc/BRIEF.md
# Gated Up/Down Event Counter with Status Snapshot

The block counts pulses on a single count input. A pulse counts when the synchronised input has a rising edge and the synchronised gate input is high. The count goes up or down according to a direction input, which a configuration bit can invert. A second configuration bit selects the width of the accumulator: 16 bits or 24 bits. The accumulator wraps in both directions at the selected width.

Two flags come from the accumulator. The preset flag follows an equality compare against a 16-bit preset value. In the 24-bit mode that compare uses the top sixteen accumulator bits, so the preset works in blocks of 256 counts. The maximum flag is set when a count step lands on the all-ones value. It stays set until the host changes the level of a clear bit, in either direction.

The host reads a registered snapshot of the count and of a 16-bit status word. The snapshot is loaded by an update strobe, so the two values always belong to the same cycle.

Top module: `evt_counter`

## Requirements
- R1: A count step occurs once for each rising edge of `cnt_in` seen after two synchronising flops, and only while the synchronised `gate_in` is high. A pulse taken while the gate is low leaves the count unchanged.
- R2: The effective direction is `dir_in` XOR `cfg_invert`. A value of 1 counts up, 0 counts down. So with `cfg_invert`=1, `dir_in`=0 counts up.
- R3: With `cfg_wide`=0 the accumulator is 16 bits wide. An up step from 0xFFFF gives 0, a down step from 0 gives 0xFFFF, and `count_out[23:16]` reads 0.
- R4: With `cfg_wide`=1 the accumulator is 24 bits wide. An up step from 0xFFFFFF gives 0, and a down step from 0 gives 0xFFFFFF.
- R5: Status bit 15 is 1 exactly when the compared accumulator field equals `preset`. In the 16-bit mode the field is bits [15:0]; in the 24-bit mode it is bits [23:8]. The bit clears once a step moves the field off the preset value.
- R6: Status bit 9 is set by a step that lands on the all-ones value of the selected width. It stays set through later steps, including a roll to zero.
- R7: Any change in the level of `cfg_flag_clr`, rising or falling, clears status bit 9. A set in the same cycle takes priority.
- R8: Status bit 14 shows the synchronised gate level, bit 13 shows `cfg_invert`, and bit 10 shows `cfg_wide`.
- R9: Status bit 12 shows the synchronised `cnt_in` level and bit 11 the synchronised `dir_in` level. Bits 8 to 0 read 0.
- R10: `count_out` and `status_out` load only in the cycle after `update` is sampled high. Otherwise they hold.
- R11: A synchronous `rst` clears the accumulator, both flags and both snapshot outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_in | input | 1 | Asynchronous count pulse input |
| dir_in | input | 1 | Asynchronous direction input, 1 = up |
| gate_in | input | 1 | Asynchronous count enable |
| cfg_invert | input | 1 | Inverts the counting direction |
| cfg_wide | input | 1 | 0 = 16-bit accumulator, 1 = 24-bit accumulator |
| cfg_flag_clr | input | 1 | Any level change clears the maximum flag |
| preset | input | 16 | Preset compare value |
| update | input | 1 | Loads the count/status snapshot |
| count_out | output | 24 | Snapshot of the accumulator, masked to the selected width |
| status_out | output | 16 | Snapshot of the status word |

## Verification
The hardest states to reach from the ports are the 24-bit wraps and the 24-bit preset match on the top block. Reaching them by counting up would take sixteen million pulses. The stimulus gets there by stepping down from zero instead, which lands on 0xFFFFFF. It then sets `preset` to 0xFFFF and counts up once to pass through the wrap. Random steps then run with the width bit, gate, direction, invert, clear toggles and preset all changing. Each snapshot is compared with a bench model that keeps the raw accumulator, so narrowing after wide counting is covered too.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Layout of the host-visible status word, most significant bit first.
    typedef struct packed {
        logic       preset_hit;   // 15
        logic       gate_lvl;     // 14
        logic       invert;       // 13
        logic       cnt_lvl;      // 12
        logic       dir_lvl;      // 11
        logic       wide;         // 10
        logic       max_hit;      // 9
        logic [8:0] zero;         // 8..0
    } evc_status_t;

    localparam int unsigned STATUS_W = $bits(evc_status_t);

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_in,
    input  logic dir_in,
    input  logic gate_in,
    output logic cnt_lvl,
    output logic dir_lvl,
    output logic gate_lvl,
    output logic cnt_rise
);

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic [STAGES-1:0] dir;
        logic [STAGES-1:0] gate;
        logic              cnt_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.cnt      = {st_q.cnt[STAGES-2:0], cnt_in};
        st_d.dir      = {st_q.dir[STAGES-2:0], dir_in};
        st_d.gate     = {st_q.gate[STAGES-2:0], gate_in};
        st_d.cnt_prev = st_q.cnt[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_lvl  = st_q.cnt[STAGES-1];
    assign dir_lvl  = st_q.dir[STAGES-1];
    assign gate_lvl = st_q.gate[STAGES-1];
    assign cnt_rise = st_q.cnt[STAGES-1] & ~st_q.cnt_prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cnt_rise |=> !cnt_rise);  // R1

endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
    parameter int unsigned ACC_W    = 24,
    parameter int unsigned NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             up,
    input  logic             wide,
    output logic [ACC_W-1:0] acc_view,
    output logic             max_set
);

    localparam logic [ACC_W-1:0] MASK_WIDE   = '1;
    localparam logic [ACC_W-1:0] MASK_NARROW = {{(ACC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [ACC_W-1:0] ONE         = ACC_W'(1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t             st_d, st_q;
    logic [ACC_W-1:0] mask;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] nxt;

    always_comb begin
        mask    = wide ? MASK_WIDE : MASK_NARROW;
        base    = st_q.acc & mask;
        nxt     = (up ? base + ONE : base - ONE) & mask;
        st_d    = st_q;
        if (step) st_d.acc = nxt;
        max_set = step && (nxt == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_view = st_q.acc & mask;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> st_q.acc == $past(st_q.acc));  // R1
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (step && up && base == mask) |=> st_q.acc == '0);  // R3
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step && !up && base == '0) |=> st_q.acc == $past(mask));  // R4

endmodule

// File: rtl/evc_flags.sv
module evc_flags #(
    parameter int unsigned ACC_W    = 24,
    parameter int unsigned PRESET_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ACC_W-1:0]    acc_view,
    input  logic                wide,
    input  logic [PRESET_W-1:0] preset,
    input  logic                max_set,
    input  logic                flag_clr,
    output logic                preset_hit,
    output logic                max_hit
);

    typedef struct packed {
        logic clr_prev;
        logic preset_hit;
        logic max_hit;
    } flags_t;

    flags_t             st_d, st_q;
    logic [PRESET_W-1:0] field;
    logic                toggle;

    always_comb begin
        field  = wide ? acc_view[ACC_W-1 -: PRESET_W] : acc_view[PRESET_W-1:0];
        toggle = flag_clr != st_q.clr_prev;
        st_d            = st_q;
        st_d.clr_prev   = flag_clr;
        st_d.preset_hit = (field == preset);
        st_d.max_hit    = max_set | (st_q.max_hit & ~toggle);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            st_q.clr_prev <= flag_clr;
        end else begin
            st_q <= st_d;
        end
    end

    assign preset_hit = st_q.preset_hit;
    assign max_hit    = st_q.max_hit;

    AST_MAX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (max_hit && !toggle) |=> max_hit);  // R6
    AST_MAX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (toggle && !max_set) |=> !max_hit);  // R7
    AST_MAX_SET: assert property (@(posedge clk) disable iff (rst)
        max_set |=> max_hit);  // R6

endmodule

// File: rtl/evc_snap.sv
module evc_snap #(
    parameter int unsigned ACC_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  update,
    input  logic [ACC_W-1:0]      acc_view,
    input  evc_pkg::evc_status_t  status_live,
    output logic [ACC_W-1:0]      count_out,
    output logic [evc_pkg::STATUS_W-1:0] status_out
);

    typedef struct packed {
        logic [ACC_W-1:0]     count;
        evc_pkg::evc_status_t status;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update) begin
            st_d.count  = acc_view;
            st_d.status = status_live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_out  = st_q.count;
    assign status_out = st_q.status;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !update |=> ($stable(count_out) && $stable(status_out)));  // R10

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int unsigned ACC_W       = 24,
    parameter int unsigned NARROW_W    = 16,
    parameter int unsigned PRESET_W    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_in,
    input  logic                dir_in,
    input  logic                gate_in,
    input  logic                cfg_invert,
    input  logic                cfg_wide,
    input  logic                cfg_flag_clr,
    input  logic [PRESET_W-1:0] preset,
    input  logic                update,
    output logic [ACC_W-1:0]    count_out,
    output logic [15:0]         status_out
);

    import evc_pkg::*;

    logic             cnt_lvl, dir_lvl, gate_lvl, cnt_rise;
    logic             step, up, max_set, preset_hit, max_hit;
    logic [ACC_W-1:0] acc_view;
    evc_status_t      status_live;

    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .cnt_in(cnt_in), .dir_in(dir_in), .gate_in(gate_in),
        .cnt_lvl(cnt_lvl), .dir_lvl(dir_lvl), .gate_lvl(gate_lvl),
        .cnt_rise(cnt_rise)
    );

    always_comb begin
        step = cnt_rise & gate_lvl;
        up   = dir_lvl ^ cfg_invert;
    end

    evc_accum #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_accum (
        .clk(clk), .rst(rst),
        .step(step), .up(up), .wide(cfg_wide),
        .acc_view(acc_view), .max_set(max_set)
    );

    evc_flags #(.ACC_W(ACC_W), .PRESET_W(PRESET_W)) u_flags (
        .clk(clk), .rst(rst),
        .acc_view(acc_view), .wide(cfg_wide), .preset(preset),
        .max_set(max_set), .flag_clr(cfg_flag_clr),
        .preset_hit(preset_hit), .max_hit(max_hit)
    );

    always_comb begin
        status_live            = '0;
        status_live.preset_hit = preset_hit;
        status_live.gate_lvl   = gate_lvl;
        status_live.invert     = cfg_invert;
        status_live.cnt_lvl    = cnt_lvl;
        status_live.dir_lvl    = dir_lvl;
        status_live.wide       = cfg_wide;
        status_live.max_hit    = max_hit;
    end

    evc_snap #(.ACC_W(ACC_W)) u_snap (
        .clk(clk), .rst(rst), .update(update),
        .acc_view(acc_view), .status_live(status_live),
        .count_out(count_out), .status_out(status_out)
    );

    AST_GATED_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_rise && !gate_lvl) |-> !step);  // R1

endmodule

// File: tb/evt_counter_test.sv
module evt_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_in = 0, dir_in = 0, gate_in = 0;
    logic        cfg_invert = 0, cfg_wide = 0, cfg_flag_clr = 0;
    logic [15:0] preset = 16'h1234;
    logic        update = 0;
    logic [23:0] count_out;
    logic [15:0] status_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [23:0] m_acc;
    bit          m_max;

    always #2 clk = ~clk;

    evt_counter uut (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .dir_in(dir_in), .gate_in(gate_in),
        .cfg_invert(cfg_invert), .cfg_wide(cfg_wide), .cfg_flag_clr(cfg_flag_clr),
        .preset(preset), .update(update), .count_out(count_out), .status_out(status_out)
    );

    function automatic logic [23:0] f_mask(input bit wide);
        return wide ? 24'hFFFFFF : 24'h00FFFF;
    endfunction

    function automatic bit f_match(input logic [23:0] acc, input bit wide, input logic [15:0] p);
        logic [23:0] v = acc & f_mask(wide);
        return wide ? (v[23:8] == p) : (v[15:0] == p);
    endfunction

    function automatic logic [15:0] f_status();
        return {f_match(m_acc, cfg_wide, preset), gate_in, cfg_invert, cnt_in,
                dir_in, cfg_wide, m_max, 9'b0};
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        logic [23:0] b;
        logic [23:0] mk;
        @(negedge clk) cnt_in = 1'b1;
        settle(3);
        cnt_in = 1'b0;
        settle(3);
        if (gate_in) begin
            mk = f_mask(cfg_wide);
            b  = m_acc & mk;
            m_acc = ((dir_in ^ cfg_invert) ? b + 24'd1 : b - 24'd1) & mk;
            if (m_acc == mk) m_max = 1'b1;
        end
    endtask

    task automatic lines(input bit g, input bit d);
        @(negedge clk);
        gate_in = g;
        dir_in  = d;
        settle(4);
    endtask

    task automatic toggle_clr();
        @(negedge clk) cfg_flag_clr = ~cfg_flag_clr;
        m_max = 1'b0;
        settle(2);
    endtask

    task automatic snap();
        settle(2);
        update = 1'b1;
        @(negedge clk) update = 1'b0;
    endtask

    task automatic check_all(input string req);
        snap();
        chk(req, count_out, m_acc & f_mask(cfg_wide));
        chk(req, {8'h0, status_out}, {8'h0, f_status()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_acc = '0;
        m_max = 1'b0;
        settle(4);
        chk("R11 reset count", count_out, 24'h0);
        chk("R11 reset status", {8'h0, status_out}, 24'h0);
        @(negedge clk) rst = 1'b0;

        // R10: outputs hold without update even as state changes
        lines(1, 1);
        pulse();
        chk("R10 hold count", count_out, 24'h0);
        chk("R10 hold status", {8'h0, status_out}, 24'h0);
        check_all("R10 R1 after update");

        // R1: gate low ignores pulses
        lines(0, 1);
        pulse(); pulse();
        check_all("R1 gate low");

        // R2 R3: narrow wrap down, max flag
        lines(1, 0);
        pulse(); pulse();
        check_all("R2 R3 down to wrap");
        chk("R6 max set narrow", {23'h0, status_out[9]}, 24'h1);
        lines(1, 1);
        pulse();
        check_all("R3 up wrap to zero");
        chk("R6 max sticky", {23'h0, status_out[9]}, 24'h1);

        // R7 both edges of clear
        toggle_clr();
        check_all("R7 rising clear");
        lines(1, 0); pulse(); lines(1, 1); pulse();
        toggle_clr();
        check_all("R7 falling clear");

        // R2 invert
        cfg_invert = 1'b1;
        lines(1, 0);
        pulse(); pulse();
        check_all("R2 invert up");
        chk("R2 invert count", count_out, 24'd2);

        // R5 narrow preset set then clear
        preset = 16'd3;
        pulse();
        check_all("R5 preset hit narrow");
        chk("R5 bit15 narrow", {23'h0, status_out[15]}, 24'h1);
        pulse();
        check_all("R5 preset left");
        chk("R5 bit15 clear", {23'h0, status_out[15]}, 24'h0);

        // R4 wide wrap and top-block preset
        cfg_invert = 1'b0;
        cfg_wide   = 1'b1;
        lines(1, 0);
        repeat (4) pulse();
        pulse();
        check_all("R4 wide down wrap");
        chk("R4 wide all ones", count_out, 24'hFFFFFF);
        preset = 16'hFFFF;
        check_all("R5 wide preset block");
        lines(1, 1);
        pulse();
        check_all("R4 wide up wrap");
        chk("R4 wide zero", count_out, 24'h0);

        // R9 levels of count and direction inputs
        lines(0, 1);
        @(negedge clk) cnt_in = 1'b1;
        settle(4);
        check_all("R9 cnt level");
        chk("R9 bit12", {23'h0, status_out[12]}, 24'h1);
        @(negedge clk) cnt_in = 1'b0;
        settle(4);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0: lines($urandom_range(0, 3) != 0, $urandom_range(0, 1));
                1: toggle_clr();
                2: cfg_invert = $urandom_range(0, 1);
                3: cfg_wide = $urandom_range(0, 1);
                4: preset = ($urandom_range(0, 1) != 0) ? 16'($urandom) : 16'(m_acc[15:0] + 16'd1);
                default: pulse();
            endcase
            if ((i % 5) == 4) check_all("R8 R5 R6 random");
        end

        check_all("R8 final");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule